// File: doc/BRIEF.md
# Indexed Vertex Post-Transform Cache

This block walks the vertices of one draw and decides, for each of them, whether the vertex-processing engine has to run. A draw starts with a vertex count, a start offset, an indexed flag and an index width. In non-indexed draws the vertex ID is the loop step plus the start offset. Every such vertex is sent to the engine. In indexed draws the IDs come from an index stream as 8-bit or 16-bit values. Each ID is looked up in a small fully associative store of recently processed results.

On a hit the stored payload is returned at once and no processing request is made. On a miss the block raises a request carrying the vertex ID and holds it until the engine acknowledges. The returned payload is then written into the store at a circular replacement pointer, which then advances. Either way, one result leaves on the output stream per loop step, in the original order. After the last result a single done pulse follows. The store is emptied whenever a draw starts. Cumulative hit and miss counters make the replacement behaviour visible.

Top module: `vtx_cache_top`

## Requirements
- R1: After reset the block is idle: no request, no output, no index ready, no done pulse, and both counters read zero.
- R2: In a non-indexed draw of N vertices with offset S, the block requests processing of IDs S, S+1, ..., S+N-1 in order. It emits each acknowledged payload with its ID and the hit flag low. It never looks up the store and never fills it.
- R3: In an indexed draw with the width select low, only bits [7:0] of each index are used, zero-extended to the 16-bit ID. The start offset has no effect.
- R4: In an indexed draw with the width select high, the full 16-bit index is the vertex ID.
- R5: An indexed ID whose result is held in the store is emitted with the stored payload and the hit flag high, without any processing request.
- R6: On an indexed miss, the request and its ID stay stable until acknowledged. The payload fills the entry at the replacement pointer, and the pointer then advances modulo 32. As a result, the 33rd distinct miss of a draw evicts the first one.
- R7: Starting a draw empties the store and resets the replacement pointer to 0, so no ID can hit on a result from an earlier draw.
- R8: The 16-bit index 0xFFFF is always processed and is never stored or reported as a hit.
- R9: Exactly one done pulse is given per draw, one cycle after the last output. A draw with a count of zero gives the pulse with no output and no request.
- R10: The hit counter counts indexed outputs that hit. The miss counter counts indexed outputs that needed processing. Both accumulate from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a draw when the block is idle |
| start_count_i | input | 16 | Number of vertices in the draw |
| start_offset_i | input | 16 | First vertex ID of a non-indexed draw |
| start_indexed_i | input | 1 | 1 = IDs come from the index stream |
| start_wide_i | input | 1 | 1 = 16-bit indices, 0 = 8-bit indices |
| idx_valid_i | input | 1 | Index stream word valid |
| idx_data_i | input | 16 | Index stream word |
| idx_ready_o | output | 1 | Block accepts an index this cycle |
| proc_req_o | output | 1 | Processing request |
| proc_id_o | output | 16 | Vertex ID to process |
| proc_ack_i | input | 1 | Engine acknowledges, result valid |
| proc_result_i | input | 32 | Processed vertex payload |
| out_valid_o | output | 1 | Output vertex valid (one cycle) |
| out_id_o | output | 16 | Vertex ID of the output |
| out_data_o | output | 32 | Payload of the output |
| out_hit_o | output | 1 | Output came from the store |
| draw_done_o | output | 1 | One-cycle pulse after the last output |
| hit_count_o | output | 16 | Cumulative hit count |
| miss_count_o | output | 16 | Cumulative indexed miss count |

## Verification
Several properties are checked on every cycle. No two store entries match the same key, and a request holds its ID until acknowledged. Index acceptance and a pending request never overlap. Hits appear only in indexed draws and never carry ID 0xFFFF. The store is empty after a draw starts, and the done pulse lasts one cycle. The bench scenarios show what the properties cannot: the ID sequences for both widths, that a hit returns the earlier payload unchanged, the eviction after 32 fills, the clearing between draws, the done timing, and the counter totals.

// File: rtl/vc_pkg.sv
package vc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_PROC  = 2'd2,
    ST_DONE  = 2'd3
  } vc_state_t;
endpackage

// File: rtl/vc_store.sv
module vc_store #(
  parameter int ENTRIES   = 32,
  parameter int ID_W      = 16,
  parameter int PAYLOAD_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear_i,
  input  logic [ID_W-1:0]      key_i,
  output logic                 hit_o,
  output logic [PAYLOAD_W-1:0] hit_data_o,
  input  logic                 fill_i,
  input  logic [ID_W-1:0]      fill_tag_i,
  input  logic [PAYLOAD_W-1:0] fill_data_i
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

  logic [ENTRIES-1:0]   valid_q, valid_n;
  logic [ID_W-1:0]      tag_q  [ENTRIES];
  logic [PAYLOAD_W-1:0] data_q [ENTRIES];
  logic [PTR_W-1:0]     ptr_q, ptr_n;
  logic [ENTRIES-1:0]   match;

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : g_way
      assign match[g] = valid_q[g] && (tag_q[g] == key_i);
      always_ff @(posedge clk) begin
        if (fill_i && (ptr_q == PTR_W'(g))) begin
          tag_q[g]  <= fill_tag_i;
          data_q[g] <= fill_data_i;
        end
      end
    end
  endgenerate

  assign hit_o = |match;

  always_comb begin
    hit_data_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) hit_data_o = hit_data_o | data_q[i];
    end
  end

  always_comb begin
    valid_n = valid_q;
    ptr_n   = ptr_q;
    if (clear_i) begin
      valid_n = '0;
      ptr_n   = '0;
    end else if (fill_i) begin
      valid_n[ptr_q] = 1'b1;
      ptr_n = (ptr_q == PTR_LAST) ? '0 : ptr_q + PTR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      ptr_q   <= '0;
    end else if (clear_i || fill_i) begin
      valid_q <= valid_n;
      ptr_q   <= ptr_n;
    end
  end

  a_r6_unique_tags: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !hit_o);
endmodule

// File: rtl/vc_seq.sv
module vc_seq
  import vc_pkg::*;
#(
  parameter int ID_W     = 16,
  parameter int CNT_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [ID_W-1:0]  offset_i,
  input  logic             indexed_i,
  input  logic             wide_i,
  input  logic             idx_valid_i,
  input  logic [ID_W-1:0]  idx_data_i,
  output logic             idx_ready_o,
  output logic [ID_W-1:0]  key_o,
  output logic             look_en_o,
  input  logic             look_hit_i,
  output logic             proc_req_o,
  output logic [ID_W-1:0]  proc_id_o,
  input  logic             proc_ack_i,
  output logic             emit_o,
  output logic             emit_hit_o,
  output logic [ID_W-1:0]  emit_id_o,
  output logic             fill_o,
  output logic             clear_o,
  output logic             done_o,
  output logic             indexed_o
);
  localparam logic [ID_W-1:0] ID_BAD = '1;

  vc_state_t        st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n, lim_q;
  logic [ID_W-1:0]  off_q, id_q, id_n;
  logic             idx_q, wide_q, cfg_ld;
  logic [CNT_W-1:0] cnt_inc;

  assign cfg_ld  = (st_q == ST_IDLE) && start_i;
  assign cnt_inc = cnt_q + CNT_W'(1);

  assign key_o       = wide_q ? idx_data_i : ID_W'(idx_data_i[NARROW_W-1:0]);
  assign idx_ready_o = (st_q == ST_FETCH) && idx_q;
  assign look_en_o   = idx_ready_o && idx_valid_i && (key_o != ID_BAD);
  assign proc_req_o  = (st_q == ST_PROC);
  assign proc_id_o   = id_q;
  assign emit_id_o   = (st_q == ST_PROC) ? id_q : key_o;
  assign done_o      = (st_q == ST_DONE);
  assign indexed_o   = idx_q;

  always_comb begin
    st_n       = st_q;
    cnt_n      = cnt_q;
    id_n       = id_q;
    emit_o     = 1'b0;
    emit_hit_o = 1'b0;
    fill_o     = 1'b0;
    clear_o    = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          clear_o = 1'b1;
          cnt_n   = '0;
          st_n    = (count_i == '0) ? ST_DONE : ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (!idx_q) begin
          id_n = off_q + ID_W'(cnt_q);
          st_n = ST_PROC;
        end else if (idx_valid_i) begin
          id_n = key_o;
          if (look_en_o && look_hit_i) begin
            emit_o     = 1'b1;
            emit_hit_o = 1'b1;
          end else begin
            st_n = ST_PROC;
          end
        end
      end
      ST_PROC: begin
        if (proc_ack_i) begin
          emit_o = 1'b1;
          fill_o = idx_q && (id_q != ID_BAD);
        end
      end
      default: st_n = ST_IDLE;
    endcase
    if (emit_o) begin
      cnt_n = cnt_inc;
      st_n  = (cnt_inc == lim_q) ? ST_DONE : ST_FETCH;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      id_q  <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      id_q  <= id_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q  <= '0;
      off_q  <= '0;
      idx_q  <= 1'b0;
      wide_q <= 1'b0;
    end else if (cfg_ld) begin
      lim_q  <= count_i;
      off_q  <= offset_i;
      idx_q  <= indexed_i;
      wide_q <= wide_i;
    end
  end

  a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_req_o && !proc_ack_i) |=> (proc_req_o && $stable(proc_id_o)));
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(idx_ready_o && proc_req_o));
endmodule

// File: rtl/vtx_cache_top.sv
module vtx_cache_top #(
  parameter int ENTRIES   = 32,
  parameter int ID_W      = 16,
  parameter int PAYLOAD_W = 32,
  parameter int CNT_W     = 16,
  parameter int NARROW_W  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [CNT_W-1:0]     start_count_i,
  input  logic [ID_W-1:0]      start_offset_i,
  input  logic                 start_indexed_i,
  input  logic                 start_wide_i,
  input  logic                 idx_valid_i,
  input  logic [ID_W-1:0]      idx_data_i,
  output logic                 idx_ready_o,
  output logic                 proc_req_o,
  output logic [ID_W-1:0]      proc_id_o,
  input  logic                 proc_ack_i,
  input  logic [PAYLOAD_W-1:0] proc_result_i,
  output logic                 out_valid_o,
  output logic [ID_W-1:0]      out_id_o,
  output logic [PAYLOAD_W-1:0] out_data_o,
  output logic                 out_hit_o,
  output logic                 draw_done_o,
  output logic [CNT_W-1:0]     hit_count_o,
  output logic [CNT_W-1:0]     miss_count_o
);
  logic [ID_W-1:0]      key, emit_id;
  logic                 look_en, look_hit, raw_hit;
  logic                 emit, emit_hit, fill, clear, seq_done, indexed;
  logic [PAYLOAD_W-1:0] hit_data;
  logic [CNT_W-1:0]     hits_q, miss_q;

  vc_seq #(.ID_W(ID_W), .CNT_W(CNT_W), .NARROW_W(NARROW_W)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .start_i(start_i), .count_i(start_count_i), .offset_i(start_offset_i),
    .indexed_i(start_indexed_i), .wide_i(start_wide_i),
    .idx_valid_i(idx_valid_i), .idx_data_i(idx_data_i), .idx_ready_o(idx_ready_o),
    .key_o(key), .look_en_o(look_en), .look_hit_i(look_hit),
    .proc_req_o(proc_req_o), .proc_id_o(proc_id_o), .proc_ack_i(proc_ack_i),
    .emit_o(emit), .emit_hit_o(emit_hit), .emit_id_o(emit_id),
    .fill_o(fill), .clear_o(clear), .done_o(seq_done), .indexed_o(indexed)
  );

  vc_store #(.ENTRIES(ENTRIES), .ID_W(ID_W), .PAYLOAD_W(PAYLOAD_W)) store_i (
    .clk(clk), .rst_n(rst_n), .clear_i(clear),
    .key_i(key), .hit_o(raw_hit), .hit_data_o(hit_data),
    .fill_i(fill), .fill_tag_i(proc_id_o), .fill_data_i(proc_result_i)
  );

  assign look_hit = look_en && raw_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      out_hit_o   <= 1'b0;
      draw_done_o <= 1'b0;
    end else begin
      out_valid_o <= emit;
      out_hit_o   <= emit && emit_hit;
      draw_done_o <= seq_done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_id_o   <= '0;
      out_data_o <= '0;
    end else if (emit) begin
      out_id_o   <= emit_id;
      out_data_o <= emit_hit ? hit_data : proc_result_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hits_q <= '0;
      miss_q <= '0;
    end else if (emit && indexed) begin
      if (emit_hit) hits_q <= hits_q + CNT_W'(1);
      else          miss_q <= miss_q + CNT_W'(1);
    end
  end

  assign hit_count_o  = hits_q;
  assign miss_count_o = miss_q;

  a_r2_hit_only_indexed: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_hit_o) |-> indexed);
  a_r8_no_bad_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_hit_o) |-> (out_id_o != '1));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    draw_done_o |=> !draw_done_o);
  a_r5_hit_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && out_hit_o) |-> !$past(proc_req_o));
endmodule

// File: tb/vtx_cache_top_tb_top.sv
`timescale 1ns/1ps
module vtx_cache_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] start_count_i = '0;
  logic [15:0] start_offset_i = '0;
  logic        start_indexed_i = 1'b0;
  logic        start_wide_i = 1'b0;
  logic        idx_valid_i = 1'b0;
  logic [15:0] idx_data_i = '0;
  logic        idx_ready_o;
  logic        proc_req_o;
  logic [15:0] proc_id_o;
  logic        proc_ack_i = 1'b0;
  logic [31:0] proc_result_i = '0;
  logic        out_valid_o;
  logic [15:0] out_id_o;
  logic [31:0] out_data_o;
  logic        out_hit_o;
  logic        draw_done_o;
  logic [15:0] hit_count_o, miss_count_o;

  always #4 clk = ~clk;

  vtx_cache_top dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_count_i(start_count_i),
    .start_offset_i(start_offset_i), .start_indexed_i(start_indexed_i),
    .start_wide_i(start_wide_i), .idx_valid_i(idx_valid_i), .idx_data_i(idx_data_i),
    .idx_ready_o(idx_ready_o), .proc_req_o(proc_req_o), .proc_id_o(proc_id_o),
    .proc_ack_i(proc_ack_i), .proc_result_i(proc_result_i), .out_valid_o(out_valid_o),
    .out_id_o(out_id_o), .out_data_o(out_data_o), .out_hit_o(out_hit_o),
    .draw_done_o(draw_done_o), .hit_count_o(hit_count_o), .miss_count_o(miss_count_o)
  );

  int checks = 0, errors = 0;
  int cyc = 0, n_out = 0, n_done = 0, n_ack = 0;
  int last_out_cyc = 0, done_cyc = 0;
  int exp_hits = 0, exp_miss = 0;
  logic [15:0] log_id [0:63];
  logic [31:0] log_data [0:63];
  logic        log_hit [0:63];
  logic [15:0] idq [0:63];
  int base;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // cycle counter and output monitor, sampled at the falling edge
  initial forever begin
    @(negedge clk);
    cyc++;
    if (out_valid_o && n_out < 64) begin
      log_id[n_out] = out_id_o;
      log_data[n_out] = out_data_o;
      log_hit[n_out] = out_hit_o;
      last_out_cyc = cyc;
      n_out++;
    end
    if (draw_done_o) begin
      n_done++;
      done_cyc = cyc;
    end
  end

  // processing engine model: two cycles of latency, payload = {sequence, id}
  initial forever begin
    @(negedge clk);
    if (proc_req_o) begin
      repeat (2) @(negedge clk);
      n_ack++;
      proc_result_i = {16'(n_ack), proc_id_o};
      proc_ack_i = 1'b1;
      @(negedge clk);
      proc_ack_i = 1'b0;
    end
  end

  task automatic run_draw(input int cnt, input int off, input bit indexed, input bit wide,
                          output int acks);
    int d0, a0;
    base = n_out;
    d0 = n_done;
    a0 = n_ack;
    @(negedge clk);
    start_i = 1'b1;
    start_count_i = 16'(cnt);
    start_offset_i = 16'(off);
    start_indexed_i = indexed;
    start_wide_i = wide;
    @(negedge clk);
    start_i = 1'b0;
    if (indexed) begin
      for (int i = 0; i < cnt; i++) begin
        idx_valid_i = 1'b1;
        idx_data_i = idq[i];
        while (!idx_ready_o) @(negedge clk);
        @(negedge clk);
      end
      idx_valid_i = 1'b0;
    end
    while (n_done == d0) @(negedge clk);
    repeat (2) @(negedge clk);
    acks = n_ack - a0;
    chk(n_done == d0 + 1, "R9", "done pulses", n_done - d0, 1);
    chk(n_out - base == cnt, "R9", "output count", n_out - base, cnt);
    if (cnt > 0) chk(done_cyc == last_out_cyc + 1, "R9", "done timing", done_cyc - last_out_cyc, 1);
  endtask

  task automatic t_reset();
    chk(!proc_req_o && !out_valid_o && !idx_ready_o && !draw_done_o, "R1", "idle outputs",
        {proc_req_o, out_valid_o, idx_ready_o, draw_done_o}, 0);
    chk(hit_count_o == 0 && miss_count_o == 0, "R1", "counters", {hit_count_o, miss_count_o}, 0);
  endtask

  task automatic t_nonindexed();
    int acks;
    run_draw(4, 100, 1'b0, 1'b0, acks);
    chk(acks == 4, "R2", "requests", acks, 4);
    for (int i = 0; i < 4; i++) begin
      chk(log_id[base+i] == 16'(100 + i), "R2", "id", log_id[base+i], 100 + i);
      chk(log_data[base+i][15:0] == 16'(100 + i) && !log_hit[base+i], "R2", "payload/hit",
          log_data[base+i], 100 + i);
    end
  endtask

  task automatic t_narrow();
    int acks;
    idq[0] = 16'h1203; idq[1] = 16'h0007; idq[2] = 16'h5503;
    run_draw(3, 999, 1'b1, 1'b0, acks);
    exp_hits += 1; exp_miss += 2;
    chk(log_id[base] == 16'h0003, "R3", "low byte id", log_id[base], 3);
    chk(log_id[base+1] == 16'h0007, "R3", "id 7", log_id[base+1], 7);
    chk(log_hit[base+2] && log_id[base+2] == 16'h0003, "R3", "upper byte ignored", log_hit[base+2], 1);
    chk(acks == 2, "R3", "requests", acks, 2);
  endtask

  task automatic t_wide_hit();
    int acks;
    idq[0] = 16'h1234; idq[1] = 16'h00AA; idq[2] = 16'h1234;
    run_draw(3, 0, 1'b1, 1'b1, acks);
    exp_hits += 1; exp_miss += 2;
    chk(log_id[base] == 16'h1234, "R4", "wide id", log_id[base], 16'h1234);
    chk(log_hit[base+2], "R5", "hit flag", log_hit[base+2], 1);
    chk(log_data[base+2] == log_data[base], "R5", "cached payload", log_data[base+2], log_data[base]);
    chk(acks == 2, "R5", "no request on hit", acks, 2);
  endtask

  task automatic t_replace();
    int acks;
    for (int i = 0; i < 33; i++) idq[i] = 16'(i);
    idq[33] = 16'd1; idq[34] = 16'd0;
    run_draw(35, 0, 1'b1, 1'b1, acks);
    exp_hits += 1; exp_miss += 34;
    chk(log_hit[base+33], "R6", "id 1 survives", log_hit[base+33], 1);
    chk(!log_hit[base+34], "R6", "id 0 evicted", log_hit[base+34], 0);
    chk(acks == 34, "R6", "requests", acks, 34);
  endtask

  task automatic t_clear();
    int acks;
    idq[0] = 16'd9;
    run_draw(1, 0, 1'b1, 1'b1, acks);
    run_draw(1, 0, 1'b1, 1'b1, acks);
    exp_miss += 2;
    chk(!log_hit[base] && acks == 1, "R7", "miss after new draw", log_hit[base], 0);
  endtask

  task automatic t_bad_index();
    int acks;
    idq[0] = 16'hFFFF; idq[1] = 16'hFFFF;
    run_draw(2, 0, 1'b1, 1'b1, acks);
    exp_miss += 2;
    chk(!log_hit[base+1] && acks == 2, "R8", "all-ones processed twice", acks, 2);
  endtask

  task automatic t_zero();
    int acks;
    run_draw(0, 5, 1'b0, 1'b0, acks);
    chk(acks == 0, "R9", "no request for empty draw", acks, 0);
  endtask

  task automatic t_counters();
    chk(hit_count_o == 16'(exp_hits), "R10", "hit count", hit_count_o, exp_hits);
    chk(miss_count_o == 16'(exp_miss), "R10", "miss count", miss_count_o, exp_miss);
  endtask

  initial begin
    bit timed_out = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    fork
      begin
        t_nonindexed();
        t_narrow();
        t_wide_hit();
        t_replace();
        t_clear();
        t_bad_index();
        t_zero();
        t_counters();
      end
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) chk(1'b0, "R9", "watchdog expired", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule